// File: doc/BRIEF.md
# Paired-Access General Register File

This block is the general-purpose register store of a 16-bit RISC core. It keeps sixteen architectural registers: twelve narrow registers of 16 bits and four wide registers of 32 bits. Every access names a register index and a size: byte, word or double-word. Byte and word accesses touch only the low part of the named register. Double-word accesses either join two neighbouring registers into a 32-bit pair or use a wide register whole. A short-register mode bit, carried with each access, picks which of the two groupings applies.

There are two combinational read ports and one main write port. Each port carries its own index, size and mode bit. A second write port loads the lowest pair in one cycle, so that reset-save logic can store a 32-bit value there. Writes take effect at the rising clock edge. A read in the same cycle as a write to the same register returns the old contents.

Top module: `pairRegFile`

## Requirements
- R1: A synchronous reset clears every register, so after reset every read of any index and any size returns zero.
- R2: Index encoding is 0..11 for the narrow registers, 12 and 13 for the two wide data registers, 14 for the return-address register and 15 for the stack pointer. A byte access (size code 0) reads bits 7:0 zero-extended to 32 bits. It writes only bits 7:0 and leaves every other bit unchanged.
- R3: A word access (size code 1) reads bits 15:0 zero-extended. On a wide register it writes only bits 15:0 and leaves bits 31:16 unchanged.
- R4: A double-word read (size code 2) of index n, for n from 0 to 11, returns the low word of register n+1 in bits 31:16 and the low word of register n in bits 15:0. This holds in both modes.
- R5: A double-word write to a pair puts data bits 15:0 into the low word of the lower-numbered member and bits 31:16 into the low word of the higher member. The upper word of any wide member stays unchanged.
- R6: With the mode bit clear, a double-word access to index 12..15 reads or writes that wide register whole.
- R7: With the mode bit set, index 12 pairs the low words of 12 and 13, and index 13 pairs the low words of 13 and the return-address register (14). Indices 14 and 15 still access their full 32-bit register.
- R8: Size code 3 is reserved. A read with it returns zero, and a write with it changes nothing.
- R9: A read of a register that is written in the same cycle returns the old value. The new value appears from the next cycle.
- R10: The save port loads data bits 15:0 into register 0 and bits 31:16 into register 1 in one cycle. On those two registers it takes priority over the main write port.
- R11: Each port applies its own mode bit, so the same register set can be read under both groupings in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Main write port enable |
| wrIdx | input | 4 | Main write register index |
| wrSize | input | 2 | Main write size: 0 byte, 1 word, 2 double-word, 3 reserved |
| wrSr | input | 1 | Main write short-register mode bit |
| wrData | input | 32 | Main write data |
| saveEn | input | 1 | Save port enable |
| saveData | input | 32 | Save value for the lowest pair |
| rdIdxA | input | 4 | Read port A index |
| rdSizeA | input | 2 | Read port A size |
| rdSrA | input | 1 | Read port A mode bit |
| rdDataA | output | 32 | Read port A data |
| rdIdxB | input | 4 | Read port B index |
| rdSizeB | input | 2 | Read port B size |
| rdSrB | input | 1 | Read port B mode bit |
| rdDataB | output | 32 | Read port B data |

## Verification
Reads are combinational. The bench therefore samples read data one nanosecond after it changes the read inputs at the falling edge, within the same cycle and before any write in that cycle lands. Writes and save loads are due on the following rising edge. The bench applies them to its own model only after that edge, so the first read that can see them comes in the next cycle. This ordering also checks the old-value rule of R9 whenever a random read hits the register being written.

// File: rtl/rfPkg.sv
package rfPkg;
  parameter int RF_DATA_W   = 16;
  parameter int RF_NUM_REGS = 16;
  parameter int RF_NARROW   = 12;
  localparam int RF_IDX_W   = $clog2(RF_NUM_REGS);

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_RSVD  = 2'd3
  } accSize_e;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_LOW,
    RD_PAIR,
    RD_FULL
  } rdKind_e;

  // strobes from control to datapath for the write side
  typedef struct packed {
    logic [RF_NUM_REGS-1:0] lowByteEn;   // bits of the low byte
    logic [RF_NUM_REGS-1:0] highByteEn;  // second byte of the low word
    logic [RF_NUM_REGS-1:0] upperEn;     // upper word (wide only)
    logic [RF_NUM_REGS-1:0] takeHigh;    // low word sourced from data[31:16]
    logic                   saveEn;
  } wrStrobe_t;

  // read selection for one port
  typedef struct packed {
    rdKind_e             kind;
    logic                byteOnly;
    logic [RF_IDX_W-1:0] loIdx;
    logic [RF_IDX_W-1:0] hiIdx;
  } rdSel_t;
endpackage

// File: rtl/rfCtrl.sv
module rfCtrl
  import rfPkg::*;
#(
  parameter int NUM_REGS   = RF_NUM_REGS,
  parameter int NUM_NARROW = RF_NARROW,
  parameter int IDX_W      = RF_IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [1:0]       wrSize,
  input  logic             wrSr,
  input  logic             saveEn,
  input  logic [IDX_W-1:0] rdIdxA,
  input  logic [1:0]       rdSizeA,
  input  logic             rdSrA,
  input  logic [IDX_W-1:0] rdIdxB,
  input  logic [1:0]       rdSizeB,
  input  logic             rdSrB,
  output wrStrobe_t        wrStb,
  output rdSel_t           selA,
  output rdSel_t           selB
);
  // Highest index that may start a pair in mode-set grouping.
  localparam int LAST_SR_PAIR = NUM_REGS - 3;

  function automatic logic isPair(input logic [IDX_W-1:0] idx, input logic sr);
    return (int'(idx) < NUM_NARROW) || (sr && (int'(idx) <= LAST_SR_PAIR));
  endfunction

  function automatic rdSel_t decodeRead(input logic [IDX_W-1:0] idx,
                                        input logic [1:0] size,
                                        input logic sr);
    rdSel_t s;
    s.loIdx    = idx;
    s.hiIdx    = idx + 1'b1;
    s.byteOnly = 1'b0;
    s.kind     = RD_NONE;
    case (accSize_e'(size))
      SZ_BYTE: begin
        s.kind     = RD_LOW;
        s.byteOnly = 1'b1;
      end
      SZ_WORD:  s.kind = RD_LOW;
      SZ_DWORD: s.kind = isPair(idx, sr) ? RD_PAIR : RD_FULL;
      default:  s.kind = RD_NONE;
    endcase
    return s;
  endfunction

  assign selA = decodeRead(rdIdxA, rdSizeA, rdSrA);
  assign selB = decodeRead(rdIdxB, rdSizeB, rdSrB);

  logic [IDX_W-1:0] wrHiIdx;
  assign wrHiIdx = wrIdx + 1'b1;

  always_comb begin
    wrStb        = '0;
    wrStb.saveEn = saveEn;
    if (wrEn) begin
      case (accSize_e'(wrSize))
        SZ_BYTE: wrStb.lowByteEn[wrIdx] = 1'b1;
        SZ_WORD: begin
          wrStb.lowByteEn[wrIdx]  = 1'b1;
          wrStb.highByteEn[wrIdx] = 1'b1;
        end
        SZ_DWORD: begin
          wrStb.lowByteEn[wrIdx]  = 1'b1;
          wrStb.highByteEn[wrIdx] = 1'b1;
          if (isPair(wrIdx, wrSr)) begin
            wrStb.lowByteEn[wrHiIdx]  = 1'b1;
            wrStb.highByteEn[wrHiIdx] = 1'b1;
            wrStb.takeHigh[wrHiIdx]   = 1'b1;
          end else begin
            wrStb.upperEn[wrIdx] = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  AST_RSVD_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    (wrSize == SZ_RSVD) |-> (wrStb.lowByteEn == '0 && wrStb.highByteEn == '0 && wrStb.upperEn == '0)); // R8

  AST_DWORD_SHAPE: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrSize == SZ_DWORD) |-> (($countones(wrStb.highByteEn) == 2 && wrStb.upperEn == '0) ||
                                      ($countones(wrStb.highByteEn) == 1 && $onehot0(wrStb.upperEn) && wrStb.upperEn != '0))); // R5

  AST_UPPER_ONLY_WIDE: assert property (@(posedge clk) disable iff (rst)
    wrStb.upperEn[NUM_NARROW-1:0] == '0); // R6

  AST_NARROW_NO_UPPER: assert property (@(posedge clk) disable iff (rst)
    (wrSize != SZ_DWORD) |-> (wrStb.upperEn == '0 && wrStb.takeHigh == '0)); // R3
endmodule

// File: rtl/rfData.sv
module rfData
  import rfPkg::*;
#(
  parameter int DATA_W     = RF_DATA_W,
  parameter int NUM_REGS   = RF_NUM_REGS,
  parameter int NUM_NARROW = RF_NARROW,
  parameter int IDX_W      = RF_IDX_W
) (
  input  logic                clk,
  input  logic                rst,
  input  wrStrobe_t           wrStb,
  input  logic [2*DATA_W-1:0] wrData,
  input  logic [2*DATA_W-1:0] saveData,
  input  rdSel_t              selA,
  input  rdSel_t              selB,
  output logic [2*DATA_W-1:0] rdDataA,
  output logic [2*DATA_W-1:0] rdDataB
);
  localparam int BYTE_W = DATA_W / 2;
  localparam int WIDE_W = 2 * DATA_W;

  logic [DATA_W-1:0] loWord [NUM_REGS];
  logic [DATA_W-1:0] upWord [NUM_REGS];

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : gReg
    localparam bit SAVE_SLOT = (gi < 2);
    localparam bit IS_WIDE   = (gi >= NUM_NARROW);

    logic [DATA_W-1:0] srcWord;
    logic [DATA_W-1:0] savePart;
    logic              saveHit;

    assign srcWord  = wrStb.takeHigh[gi] ? wrData[WIDE_W-1:DATA_W] : wrData[DATA_W-1:0];
    assign savePart = (gi == 0) ? saveData[DATA_W-1:0] : saveData[WIDE_W-1:DATA_W];
    assign saveHit  = SAVE_SLOT && wrStb.saveEn;

    always_ff @(posedge clk) begin
      if (rst) begin
        loWord[gi] <= '0;
      end else if (saveHit) begin
        loWord[gi] <= savePart;
      end else begin
        if (wrStb.lowByteEn[gi])  loWord[gi][BYTE_W-1:0]      <= srcWord[BYTE_W-1:0];
        if (wrStb.highByteEn[gi]) loWord[gi][DATA_W-1:BYTE_W] <= srcWord[DATA_W-1:BYTE_W];
      end
    end

    always_ff @(posedge clk) begin
      if (rst || !IS_WIDE) begin
        upWord[gi] <= '0;
      end else if (wrStb.upperEn[gi]) begin
        upWord[gi] <= wrData[WIDE_W-1:DATA_W];
      end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (loWord[gi] == '0 && upWord[gi] == '0)); // R1

    AST_BYTE_KEEPS_HIGH: assert property (@(posedge clk) disable iff (rst)
      (wrStb.lowByteEn[gi] && !wrStb.highByteEn[gi] && !saveHit)
        |=> $stable(loWord[gi][DATA_W-1:BYTE_W])); // R2

    AST_WORD_KEEPS_UPPER: assert property (@(posedge clk) disable iff (rst)
      (!wrStb.upperEn[gi]) |=> $stable(upWord[gi])); // R3
  end

  function automatic logic [WIDE_W-1:0] readSel(input rdSel_t s);
    logic [WIDE_W-1:0] r;
    case (s.kind)
      RD_LOW:  r = s.byteOnly ? {{(WIDE_W-BYTE_W){1'b0}}, loWord[s.loIdx][BYTE_W-1:0]}
                              : {{DATA_W{1'b0}}, loWord[s.loIdx]};
      RD_PAIR: r = {loWord[s.hiIdx], loWord[s.loIdx]};
      RD_FULL: r = {upWord[s.loIdx], loWord[s.loIdx]};
      default: r = '0;
    endcase
    return r;
  endfunction

  assign rdDataA = readSel(selA);
  assign rdDataB = readSel(selB);

  AST_SAVE_LOADS: assert property (@(posedge clk) disable iff (rst)
    wrStb.saveEn |=> (loWord[0] == $past(saveData[DATA_W-1:0]) &&
                      loWord[1] == $past(saveData[WIDE_W-1:DATA_W]))); // R10
endmodule

// File: rtl/pairRegFile.sv
module pairRegFile
  import rfPkg::*;
#(
  parameter int DATA_W     = RF_DATA_W,
  parameter int NUM_REGS   = RF_NUM_REGS,
  parameter int NUM_NARROW = RF_NARROW,
  localparam int IDX_W     = $clog2(NUM_REGS),
  localparam int WIDE_W    = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [1:0]        wrSize,
  input  logic              wrSr,
  input  logic [WIDE_W-1:0] wrData,
  input  logic              saveEn,
  input  logic [WIDE_W-1:0] saveData,
  input  logic [IDX_W-1:0]  rdIdxA,
  input  logic [1:0]        rdSizeA,
  input  logic              rdSrA,
  output logic [WIDE_W-1:0] rdDataA,
  input  logic [IDX_W-1:0]  rdIdxB,
  input  logic [1:0]        rdSizeB,
  input  logic              rdSrB,
  output logic [WIDE_W-1:0] rdDataB
);
  wrStrobe_t wrStb;
  rdSel_t    selA;
  rdSel_t    selB;

  rfCtrl #(
    .NUM_REGS  (NUM_REGS),
    .NUM_NARROW(NUM_NARROW),
    .IDX_W     (IDX_W)
  ) uCtrl (
    .clk    (clk),
    .rst    (rst),
    .wrEn   (wrEn),
    .wrIdx  (wrIdx),
    .wrSize (wrSize),
    .wrSr   (wrSr),
    .saveEn (saveEn),
    .rdIdxA (rdIdxA),
    .rdSizeA(rdSizeA),
    .rdSrA  (rdSrA),
    .rdIdxB (rdIdxB),
    .rdSizeB(rdSizeB),
    .rdSrB  (rdSrB),
    .wrStb  (wrStb),
    .selA   (selA),
    .selB   (selB)
  );

  rfData #(
    .DATA_W    (DATA_W),
    .NUM_REGS  (NUM_REGS),
    .NUM_NARROW(NUM_NARROW),
    .IDX_W     (IDX_W)
  ) uData (
    .clk     (clk),
    .rst     (rst),
    .wrStb   (wrStb),
    .wrData  (wrData),
    .saveData(saveData),
    .selA    (selA),
    .selB    (selB),
    .rdDataA (rdDataA),
    .rdDataB (rdDataB)
  );

  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rdSizeA == SZ_RSVD) |-> (rdDataA == '0)); // R8
endmodule

// File: tb/tb_pairRegFile.sv
`timescale 1ns/1ps
module tb_pairRegFile;
  logic        clk = 1'b0;
  logic        rst;
  logic        wrEn, wrSr, saveEn, rdSrA, rdSrB;
  logic [3:0]  wrIdx, rdIdxA, rdIdxB;
  logic [1:0]  wrSize, rdSizeA, rdSizeB;
  logic [31:0] wrData, saveData, rdDataA, rdDataB;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [15:0] refLo [16];
  logic [15:0] refUp [16];

  always #2.5 clk = ~clk;

  pairRegFile dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrIdx(wrIdx), .wrSize(wrSize), .wrSr(wrSr),
    .wrData(wrData), .saveEn(saveEn), .saveData(saveData),
    .rdIdxA(rdIdxA), .rdSizeA(rdSizeA), .rdSrA(rdSrA), .rdDataA(rdDataA),
    .rdIdxB(rdIdxB), .rdSizeB(rdSizeB), .rdSrB(rdSrB), .rdDataB(rdDataB)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic bit pairOf(input int idx, input bit sr);
    return (idx < 12) || (sr && idx < 14);
  endfunction

  function automatic logic [31:0] refRead(input int idx, input int size, input bit sr);
    case (size)
      0: return {24'h0, refLo[idx][7:0]};
      1: return {16'h0, refLo[idx]};
      2: return pairOf(idx, sr) ? {refLo[idx+1], refLo[idx]} : {refUp[idx], refLo[idx]};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tagOf(input int idx, input int size, input bit sr);
    if (size == 3) return "R8";
    if (size == 0) return "R2";
    if (size == 1) return "R3";
    if (idx < 12) return "R4";
    return sr ? "R7" : "R6";
  endfunction

  task automatic refWrite(input bit en, input int idx, input int size, input bit sr,
                          input logic [31:0] d, input bit sv, input logic [31:0] sd);
    if (en) begin
      case (size)
        0: refLo[idx][7:0] = d[7:0];
        1: refLo[idx] = d[15:0];
        2: begin
          refLo[idx] = d[15:0];
          if (pairOf(idx, sr)) refLo[idx+1] = d[31:16];
          else refUp[idx] = d[31:16];
        end
        default: ;
      endcase
    end
    if (sv) begin
      refLo[0] = sd[15:0];
      refLo[1] = sd[31:16];
    end
  endtask

  // one write cycle: drive at falling edge, model updated after the rising edge
  task automatic doWrite(input int idx, input int size, input bit sr, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = 4'(idx); wrSize = 2'(size); wrSr = sr; wrData = d; saveEn = 1'b0;
    @(posedge clk);
    refWrite(1'b1, idx, size, sr, d, 1'b0, 32'h0);
  endtask

  task automatic doRead(input int idx, input int size, input bit sr, output logic [31:0] v);
    @(negedge clk);
    wrEn = 1'b0; saveEn = 1'b0;
    rdIdxA = 4'(idx); rdSizeA = 2'(size); rdSrA = sr;
    #1 v = rdDataA;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 16; i++) begin refLo[i] = '0; refUp[i] = '0; end
    rst = 1'b1; wrEn = 0; wrIdx = 0; wrSize = 0; wrSr = 0; wrData = 0;
    saveEn = 0; saveData = 0; rdIdxA = 0; rdSizeA = 0; rdSrA = 0;
    rdIdxB = 0; rdSizeB = 0; rdSrB = 0;
    // dirty registers before reset
    @(negedge clk); rst = 1'b0;
    wrEn = 1'b1; wrIdx = 4'd15; wrSize = 2'd2; wrData = 32'hFFFF_FFFF; saveEn = 1'b1; saveData = 32'h1234_5678;
    @(negedge clk); wrEn = 1'b0; saveEn = 1'b0; rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;

    // R1: all zero after reset
    for (int i = 0; i < 16; i++) begin
      doRead(i, 2, 1'b0, v); check("R1", v, 32'h0);
    end

    // R2: byte write keeps bits 15:8
    doWrite(3, 1, 0, 32'h0000_ABCD);
    doWrite(3, 0, 0, 32'hFFFF_FF12);
    doRead(3, 1, 0, v); check("R2", v, 32'h0000_AB12);
    doRead(3, 0, 0, v); check("R2", v, 32'h0000_0012);

    // R3 / R6: word write to wide register keeps upper word
    doWrite(15, 2, 0, 32'h1122_3344);
    doWrite(15, 1, 0, 32'hAAAA_5566);
    doRead(15, 2, 0, v); check("R3", v, 32'h1122_5566);
    doRead(15, 2, 1, v); check("R6", v, 32'h1122_5566);

    // R5 / R4: pair write splits, pair read joins
    doWrite(4, 2, 0, 32'hDEAD_BEEF);
    doRead(4, 1, 0, v); check("R5", v, 32'h0000_BEEF);
    doRead(5, 1, 0, v); check("R5", v, 32'h0000_DEAD);
    doRead(4, 2, 1, v); check("R4", v, 32'hDEAD_BEEF);

    // R7: mode-set pair (13, RA) leaves RA upper word intact
    doWrite(14, 2, 0, 32'h9988_7766);
    doWrite(13, 2, 0, 32'h5555_4444);
    doWrite(13, 2, 1, 32'hCAFE_0123);
    doRead(14, 2, 1, v); check("R7", v, 32'h9988_CAFE);
    doRead(13, 2, 0, v); check("R7", v, 32'h5555_0123);

    // R8: reserved size writes nothing, reads zero
    doWrite(2, 1, 0, 32'h0000_2222);
    doWrite(2, 3, 0, 32'hFFFF_FFFF);
    doRead(2, 1, 0, v); check("R8", v, 32'h0000_2222);
    doRead(2, 3, 0, v); check("R8", v, 32'h0);

    // R9: read during write returns the old value
    doWrite(6, 1, 0, 32'h0000_1111);
    @(negedge clk);
    wrEn = 1; wrIdx = 4'd6; wrSize = 2'd1; wrSr = 0; wrData = 32'h0000_7777;
    rdIdxA = 4'd6; rdSizeA = 2'd1; rdSrA = 0;
    #1 check("R9", rdDataA, 32'h0000_1111);
    @(posedge clk); refWrite(1, 6, 1, 0, 32'h0000_7777, 0, 0);
    doRead(6, 1, 0, v); check("R9", v, 32'h0000_7777);

    // R10: save port wins over main write on register 0
    @(negedge clk);
    wrEn = 1; wrIdx = 4'd0; wrSize = 2'd1; wrSr = 0; wrData = 32'h0000_FFFF;
    saveEn = 1; saveData = 32'h8765_4321;
    @(posedge clk); refWrite(1, 0, 1, 0, 32'h0000_FFFF, 1, 32'h8765_4321);
    doRead(0, 2, 0, v); check("R10", v, 32'h8765_4321);

    // R11: per-port mode bits, same cycle
    doWrite(12, 2, 0, 32'hA1A2_B1B2);
    doWrite(12, 2, 1, 32'hC1C2_D1D2);
    @(negedge clk);
    rdIdxA = 4'd12; rdSizeA = 2'd2; rdSrA = 1'b0;
    rdIdxB = 4'd12; rdSizeB = 2'd2; rdSrB = 1'b1;
    #1;
    check("R11", rdDataA, 32'hA1A2_D1D2);
    check("R11", rdDataB, 32'hC1C2_D1D2);

    // random phase against the bench model
    void'($urandom(32'h00C0_FFEE));
    for (int n = 0; n < 3000; n++) begin
      int wi, ws, ai, as_, bi, bs;
      bit wsr, asr, bsr, we, sv;
      logic [31:0] wd, sd;
      wi = $urandom_range(15); ws = $urandom_range(3); wsr = 1'($urandom_range(1));
      ai = $urandom_range(15); as_ = $urandom_range(3); asr = 1'($urandom_range(1));
      bi = $urandom_range(15); bs = $urandom_range(3); bsr = 1'($urandom_range(1));
      we = ($urandom_range(3) != 0); sv = ($urandom_range(7) == 0);
      wd = $urandom; sd = $urandom;
      @(negedge clk);
      wrEn = we; wrIdx = 4'(wi); wrSize = 2'(ws); wrSr = wsr; wrData = wd;
      saveEn = sv; saveData = sd;
      rdIdxA = 4'(ai); rdSizeA = 2'(as_); rdSrA = asr;
      rdIdxB = 4'(bi); rdSizeB = 2'(bs); rdSrB = bsr;
      #1;
      check(tagOf(ai, as_, asr), rdDataA, refRead(ai, as_, asr));
      check(tagOf(bi, bs, bsr), rdDataB, refRead(bi, bs, bsr));
      @(posedge clk);
      refWrite(we, wi, ws, wsr, wd, sv, sd);
    end

    @(negedge clk); wrEn = 0; saveEn = 0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule